// File: doc/BRIEF.md
# Key-Guarded Register Write Protection

This block sits between a simple register bus and a small bank of configuration words. It can lock that bank against software writes. A control register holds a protection enable bit. Software can change that bit only when the same write carries a fixed 24-bit password in the upper bits of the data word. A write with any other key leaves the enable bit as it was.

While protection is on, any write that targets the guarded bank is dropped. The attempt is recorded in a status register as a sticky violation flag together with the byte offset of the targeted word. Reading the status register returns the record and then clears it. While protection is off, the guarded words behave as ordinary storage. Read data is registered and appears the cycle after the read strobe.

Top module: `wprot_guard`

## Requirements
- R1: After reset, protection is off and both the control register (offset 0xE4) and the status register (offset 0xE8) read as zero.
- R2: A write to offset 0xE4 whose bits 31:8 equal 0x534D43 loads bit 0 of the data into the protection enable. Any other value in bits 31:8 leaves the enable unchanged.
- R3: A read of offset 0xE4 returns the enable in bit 0, and all other bits, including the key field, read as zero.
- R4: With protection off, a write to a guarded offset (0x00 to 0x3F, word aligned) stores the data, a later read of that offset returns it, and the status register stays clear.
- R5: With protection on, a write to a guarded offset leaves the stored word unchanged.
- R6: With protection on, a write to a guarded offset sets status bit 0 and places that byte offset in status bits 23:8. The most recent blocked write sets the offset. All other status bits read as zero.
- R7: A read of offset 0xE8 returns the current status and clears both the flag and the offset field, so the next read returns zero.
- R8: Reads of offsets outside the guarded bank, the control register and the status register return zero. Writes to them, and writes to the status register, change nothing.
- R9: Read data for a read strobe in one cycle is presented on rdata in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | ADDR_W (8) | Byte offset, word aligned |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data, valid the cycle after rd_en |

## Verification
The assertions assume that a read and a write never share a cycle and that every offset is word aligned. They therefore do not define which of a status read and a blocked write wins if both arrive together. The bench drives one single-cycle operation at a time, always with aligned offsets, and separates each read from the next access. It sweeps every guarded word with protection both off and on, and tries several wrong keys before the correct one.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
  localparam logic [23:0] UNLOCK_KEY = 24'h534D43;
  localparam int          KEY_LSB    = 8;
  localparam int          KEY_W      = 24;
  localparam int          SRC_LSB    = 8;
  localparam int          SRC_W      = 16;
  localparam logic [7:0]  OFS_CTRL   = 8'hE4;
  localparam logic [7:0]  OFS_STAT   = 8'hE8;

  typedef struct packed {
    logic wr_guard;
    logic rd_guard;
    logic wr_ctrl;
    logic rd_ctrl;
    logic rd_stat;
  } wprot_dec_t;
endpackage

// File: rtl/wprot_decode.sv
module wprot_decode #(
  parameter int ADDR_W      = 8,
  parameter int GUARD_WORDS = 16
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output wprot_pkg::wprot_dec_t dec
);
  import wprot_pkg::*;
  localparam logic [ADDR_W-1:0] GUARD_LIMIT = ADDR_W'(GUARD_WORDS * 4);
  localparam logic [ADDR_W-1:0] A_CTRL      = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT      = ADDR_W'(OFS_STAT);

  logic in_guard;
  assign in_guard = (addr < GUARD_LIMIT);

  always_comb begin
    dec.wr_guard = wr_en & in_guard;
    dec.rd_guard = rd_en & in_guard;
    dec.wr_ctrl  = wr_en & (addr == A_CTRL);
    dec.rd_ctrl  = rd_en & (addr == A_CTRL);
    dec.rd_stat  = rd_en & (addr == A_STAT);
  end
endmodule

// File: rtl/wprot_bank.sv
module wprot_bank #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 16
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic                     re,
  input  logic [$clog2(WORDS)-1:0] idx,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rdata
);
  logic [DATA_W-1:0] mem [WORDS];

  // Plain synchronous write and read port, no reset, so block RAM can hold it.
  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    if (re) rdata <= mem[idx];
  end
endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  wprot_pkg::wprot_dec_t dec,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  output logic                  prot_en,
  output logic                  viol_flag,
  output logic [wprot_pkg::SRC_W-1:0] viol_src,
  output logic                  bank_we,
  output logic [DATA_W-1:0]     ctl_rdata
);
  import wprot_pkg::*;

  logic key_ok;
  assign key_ok  = (wdata[KEY_LSB +: KEY_W] == UNLOCK_KEY);
  assign bank_we = dec.wr_guard & ~prot_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      prot_en <= 1'b0;
    end else if (dec.wr_ctrl && key_ok) begin
      prot_en <= wdata[0];
    end
  end

  // A blocked write takes precedence over a status read in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      viol_flag <= 1'b0;
      viol_src  <= '0;
    end else if (dec.wr_guard && prot_en) begin
      viol_flag <= 1'b1;
      viol_src  <= SRC_W'(addr);
    end else if (dec.rd_stat) begin
      viol_flag <= 1'b0;
      viol_src  <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_rdata <= '0;
    end else if (dec.rd_ctrl) begin
      ctl_rdata <= DATA_W'(prot_en);
    end else if (dec.rd_stat) begin
      ctl_rdata <= '0;
      ctl_rdata[0] <= viol_flag;
      ctl_rdata[SRC_LSB +: SRC_W] <= viol_src;
    end else begin
      ctl_rdata <= '0;
    end
  end
endmodule

// File: rtl/wprot_guard.sv
module wprot_guard #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int GUARD_WORDS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  import wprot_pkg::*;
  localparam int IDX_W = $clog2(GUARD_WORDS);

  wprot_dec_t          dec;
  logic                prot_en;
  logic                viol_flag;
  logic [SRC_W-1:0]    viol_src;
  logic                bank_we;
  logic [DATA_W-1:0]   bank_q;
  logic [DATA_W-1:0]   ctl_q;
  logic                sel_bank_q;

  wprot_decode #(.ADDR_W(ADDR_W), .GUARD_WORDS(GUARD_WORDS)) u_dec (
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .dec(dec)
  );

  wprot_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .dec(dec), .addr(addr), .wdata(wdata),
    .prot_en(prot_en), .viol_flag(viol_flag), .viol_src(viol_src),
    .bank_we(bank_we), .ctl_rdata(ctl_q)
  );

  wprot_bank #(.DATA_W(DATA_W), .WORDS(GUARD_WORDS)) u_bank (
    .clk(clk), .we(bank_we), .re(dec.rd_guard),
    .idx(addr[2 +: IDX_W]), .wdata(wdata), .rdata(bank_q)
  );

  always_ff @(posedge clk) begin
    if (rst) sel_bank_q <= 1'b0;
    else     sel_bank_q <= dec.rd_guard;
  end

  assign rdata = sel_bank_q ? bank_q : ctl_q;
endmodule

// File: rtl/wprot_guard_chk.sv
module wprot_guard_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              prot_en,
  input logic              viol_flag,
  input logic [15:0]       viol_src
);
  import wprot_pkg::*;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!prot_en && !viol_flag && viol_src == 16'h0));

  a_r2_bad_key_holds: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_CTRL && wdata[31:8] != UNLOCK_KEY) |=> $stable(prot_en));

  a_r3_key_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_CTRL) |=> (rdata[DATA_W-1:1] == '0));

  a_r6_block_logs: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_en && addr < ADDR_W'(64) && prot_en)
      |=> (viol_flag && viol_src == 16'($past(addr))));

  a_r4_open_no_violation: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !prot_en && !viol_flag) |=> !viol_flag);

  a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && addr == A_STAT) |=> (!viol_flag && viol_src == 16'h0));
endmodule

bind wprot_guard wprot_guard_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .prot_en(prot_en),
  .viol_flag(viol_flag), .viol_src(viol_src)
);

// File: tb/wprot_guard_tb.sv
module wprot_guard_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int applied = 0;
  int bad = 0;
  logic [31:0] model [16];

  always #10 clk = ~clk;

  wprot_guard u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  // Read strobe for one cycle; rdata is sampled at the next falling edge (R9).
  task automatic rd_check(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    applied++;
    if (rdata !== exp) begin
      bad++;
      $display("FAIL %s addr=%02h actual=%08h expected=%08h", req, a, rdata, exp);
    end
  endtask

  function automatic logic [31:0] pattern(input int i, input int salt);
    return 32'hA5000000 ^ (32'(i) * 32'h01010101) ^ (32'(salt) << 4);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd_check(8'hE4, 32'h0, "R1");
    rd_check(8'hE8, 32'h0, "R1");

    // R4 open writes across the whole bank, R9 read timing
    for (int i = 0; i < 16; i++) begin
      model[i] = pattern(i, 1);
      wr(8'(i * 4), model[i]);
    end
    for (int i = 0; i < 16; i++) rd_check(8'(i * 4), model[i], "R4/R9");
    rd_check(8'hE8, 32'h0, "R4");

    // R2 wrong keys keep protection off, R3 key reads zero
    wr(8'hE4, 32'h534D4200 | 32'h1);
    rd_check(8'hE4, 32'h0, "R2");
    wr(8'hE4, 32'h00000001);
    rd_check(8'hE4, 32'h0, "R2");
    wr(8'hE4, 32'hD34D4301);
    rd_check(8'hE4, 32'h0, "R2");
    wr(8'hE4, 32'h534D4301);
    rd_check(8'hE4, 32'h1, "R2/R3");

    // R5, R6, R7 every guarded word blocked and logged
    for (int i = 0; i < 16; i++) begin
      wr(8'(i * 4), pattern(i, 7));
      rd_check(8'hE8, (32'(i * 4) << 8) | 32'h1, "R6");
      rd_check(8'hE8, 32'h0, "R7");
    end
    for (int i = 0; i < 16; i++) rd_check(8'(i * 4), model[i], "R5");

    // R6 most recent offset wins; R8 status writes ignored
    wr(8'h08, 32'hFFFFFFFF);
    wr(8'h3C, 32'hFFFFFFFF);
    wr(8'hE8, 32'h0);
    rd_check(8'hE8, 32'h00003C01, "R6/R8");
    rd_check(8'hE8, 32'h0, "R7");

    // R2 wrong key cannot clear protection
    wr(8'hE4, 32'h12345600);
    rd_check(8'hE4, 32'h1, "R2");
    wr(8'hE4, 32'h534D4300);
    rd_check(8'hE4, 32'h0, "R2");

    // R8 unmapped offsets
    wr(8'h80, 32'hDEADBEEF);
    rd_check(8'h80, 32'h0, "R8");
    rd_check(8'hFC, 32'h0, "R8");
    rd_check(8'h40, 32'h0, "R8");
    rd_check(8'hE8, 32'h0, "R8");

    // R4 writes work again after unlock
    model[5] = pattern(5, 9);
    wr(8'h14, model[5]);
    rd_check(8'h14, model[5], "R4");
    rd_check(8'hE8, 32'h0, "R4");

    // R1 reset mid-run clears protection and status
    wr(8'hE4, 32'h534D4301);
    wr(8'h00, 32'h1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd_check(8'hE4, 32'h0, "R1");
    rd_check(8'hE8, 32'h0, "R1");

    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule